// File: doc/BRIEF.md
# Paged Non-Volatile Array Write-Buffer Controller

This block sits behind a two-wire serial bus front end and runs a byte-addressed storage array that stands in for non-volatile memory. The front end has already decoded the bus bits. It hands this block one event per transfer: a device select for writing or for reading, the high or low address byte, a write data byte, a request for the next read byte, a repeated start, or a stop. For each event the block returns, one cycle later, an accept/refuse flag and, for read events, the data byte.

Write data does not reach the array straight away. It collects in a one-page buffer, and the write address steps only inside that page. A stop that closes a write with at least one buffered byte starts a commit. The commit copies the received bytes into the array and keeps the block busy for a fixed number of cycles. While busy, the block refuses every event, so a host can poll it with selects until one is accepted. Reads step through the whole array and wrap from the top back to zero. After reset the block sweeps every location to 0xFF before it accepts any traffic.

The array holds 2^(PAGE_BITS+OFS_BITS) bytes in pages of 2^OFS_BITS bytes. The defaults give 32 pages of 64 bytes. PAGE_BITS = 9 gives the full 32 KiB layout.

Top module: `eepg_pager`

## Requirements
- R1: Reset is synchronous and active high. During reset resp_valid is 0 and busy is 1. After reset is released, the array is filled with 0xFF and busy falls on the DEPTH-th rising edge. Every byte reads 0xFF until it is written.
- R2: Event codes on ev_kind are: 0 select-for-write, 1 select-for-read, 2 address high byte, 3 address low byte, 4 write data, 5 next read byte, 6 repeated start, 7 stop. Each edge that samples ev_valid high is followed by exactly one resp_valid pulse in the next cycle. There is no pulse without an event.
- R3: While busy is high, every event is refused (resp_ack 0) and changes neither the array nor the address counter.
- R4: The address is taken from a high byte followed by a low byte, only in the order select-for-write, high, low. Bits above the array size (bit 15 among them) are ignored. The page is bits [AW-1:6] and the offset is bits [5:0]. An address byte out of that order is refused.
- R5: Each accepted write data byte goes to the current offset, and then only the 6 offset bits increment. More than 64 bytes wrap inside the page, and later bytes overwrite earlier ones.
- R6: A stop after at least one accepted data byte raises busy on the next edge for exactly HOLD_CYC cycles (at least 64). Only the offsets that received data change. Busy rises for no other reason.
- R7: A stop or repeated start before any data byte (a dummy write) changes no array byte and does not raise busy. A repeated start or new select after data bytes discards them.
- R8: Write-protect is sampled when the first data byte of a write arrives. If it is high, that byte and every later data byte of the write are refused, and the following stop writes nothing. Changes of write-protect after an accepted first byte have no effect.
- R9: An accepted select-for-read or next-read event returns the byte at the address counter and then increments it over the whole array, wrapping from DEPTH-1 to 0. A next-read event is accepted only after a select-for-read.
- R10: When idle, the address counter points just past the last byte accessed. After a write this is the in-page successor of the last byte written, so a read without an address phase returns that byte.
- R11: An event that does not fit the current phase is refused and has no effect: data before the address, next-read outside a read, address bytes outside a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event strobe from the bus front end |
| ev_kind | input | 3 | Event code (see R2) |
| ev_byte | input | 8 | Address or data byte of the event |
| wp | input | 1 | Write-protect level |
| resp_valid | output | 1 | Response strobe, one cycle after an event |
| resp_ack | output | 1 | 1 = accepted, 0 = refused |
| resp_data | output | 8 | Read byte for accepted read events |
| busy | output | 1 | Init sweep or commit in progress |

## Verification
A wrong phase or a stale write-protect decision shows up on the very next response, as a flipped acknowledge. A wrong address counter or wrong buffer contents stay hidden until the next read of the affected bytes, which can be many transactions later. For that reason every write is followed by read-back, sooner or later, and the random mix re-reads whole pages. A miscounted commit shows as a wrong busy length, measured in cycles right after the stop.

// File: rtl/eepg_pkg.sv
package eepg_pkg;
  typedef enum logic [2:0] {
    EV_SEL_WR  = 3'd0,
    EV_SEL_RD  = 3'd1,
    EV_ADR_HI  = 3'd2,
    EV_ADR_LO  = 3'd3,
    EV_WDATA   = 3'd4,
    EV_RD_NEXT = 3'd5,
    EV_RESTART = 3'd6,
    EV_STOP    = 3'd7
  } ev_kind_e;

  typedef enum logic [2:0] {
    PH_INIT   = 3'd0,
    PH_IDLE   = 3'd1,
    PH_WHI    = 3'd2,
    PH_WLO    = 3'd3,
    PH_WDAT   = 3'd4,
    PH_WDROP  = 3'd5,
    PH_RD     = 3'd6,
    PH_COMMIT = 3'd7
  } phase_e;
endpackage

// File: rtl/eepg_array.sv
module eepg_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // single write port, registered read port: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eepg_page_buf.sv
module eepg_page_buf #(
  parameter int OW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [OW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [OW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          rd_mark,
  output logic          any_mark
);
  localparam int SLOTS = 1 << OW;

  logic [DW-1:0]    slot_q [SLOTS];
  logic [SLOTS-1:0] mark_q;

  always_ff @(posedge clk) begin
    if (wr_en) slot_q[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      mark_q <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (wr_en && wr_idx == OW'(i)) mark_q[i] <= 1'b1;
      end
    end
  end

  assign rd_data  = slot_q[rd_idx];
  assign rd_mark  = mark_q[rd_idx];
  assign any_mark = |mark_q;
endmodule

// File: rtl/eepg_addr_ctr.sv
module eepg_addr_ctr #(
  parameter int AW = 11,
  parameter int OW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step_page,
  input  logic          step_full,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (load) begin
      addr <= load_val;
    end else if (step_full) begin
      addr <= addr + AW'(1);
    end else if (step_page) begin
      addr[OW-1:0] <= addr[OW-1:0] + OW'(1);
    end
  end
endmodule

// File: rtl/eepg_hold_timer.sv
module eepg_hold_timer #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          run,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || start) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/eepg_pager.sv
module eepg_pager
  import eepg_pkg::*;
#(
  parameter int PAGE_BITS = 5,
  parameter int OFS_BITS  = 6,
  parameter int HOLD_CYC  = 80
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ev_valid,
  input  logic [2:0] ev_kind,
  input  logic [7:0] ev_byte,
  input  logic       wp,
  output logic       resp_valid,
  output logic       resp_ack,
  output logic [7:0] resp_data,
  output logic       busy
);
  localparam int AW      = PAGE_BITS + OFS_BITS;
  localparam int HI_W    = AW - 8;
  localparam int DEPTH   = 1 << AW;
  localparam int SLOTS   = 1 << OFS_BITS;
  localparam int HOLD    = (HOLD_CYC < SLOTS) ? SLOTS : HOLD_CYC;
  localparam int CNT_TOP = (DEPTH > HOLD) ? DEPTH : HOLD;
  localparam int CW      = $clog2(CNT_TOP) + 1;

  phase_e          phase_q, phase_d;
  ev_kind_e        kind;
  logic [HI_W-1:0] hi_q;
  logic            resp_valid_q, resp_ack_q, busy_q;

  logic            ack, hi_ld, ld, step_page, step_full;
  logic            buf_wr, buf_clr, tmr_start, tmr_run;
  logic            buf_mark, buf_any;
  logic [7:0]      buf_data;
  logic [AW-1:0]   addr_q;
  logic [CW-1:0]   cnt_q;
  logic            is_busy, init_last, hold_last;
  logic            arr_we;
  logic [AW-1:0]   arr_waddr;
  logic [7:0]      arr_wdata, arr_rdata;

  assign kind      = ev_kind_e'(ev_kind);
  assign is_busy   = (phase_q == PH_INIT) || (phase_q == PH_COMMIT);
  assign tmr_run   = is_busy;
  assign init_last = (phase_q == PH_INIT)   && (cnt_q == CW'(DEPTH - 1));
  assign hold_last = (phase_q == PH_COMMIT) && (cnt_q == CW'(HOLD - 1));

  // phase sequencing and per-event accept decision
  always_comb begin
    phase_d   = phase_q;
    ack       = 1'b0;
    hi_ld     = 1'b0;
    ld        = 1'b0;
    step_page = 1'b0;
    step_full = 1'b0;
    buf_wr    = 1'b0;
    buf_clr   = 1'b0;
    tmr_start = 1'b0;
    if (init_last) phase_d = PH_IDLE;
    if (hold_last) begin
      phase_d = PH_IDLE;
      buf_clr = 1'b1;
    end
    if (ev_valid && !is_busy) begin
      unique case (kind)
        EV_SEL_WR: begin
          ack = 1'b1; buf_clr = 1'b1; phase_d = PH_WHI;
        end
        EV_SEL_RD: begin
          ack = 1'b1; buf_clr = 1'b1; step_full = 1'b1; phase_d = PH_RD;
        end
        EV_ADR_HI: if (phase_q == PH_WHI) begin
          ack = 1'b1; hi_ld = 1'b1; phase_d = PH_WLO;
        end
        EV_ADR_LO: if (phase_q == PH_WLO) begin
          ack = 1'b1; ld = 1'b1; phase_d = PH_WDAT;
        end
        EV_WDATA: if (phase_q == PH_WDAT) begin
          if (buf_any || !wp) begin
            ack = 1'b1; buf_wr = 1'b1; step_page = 1'b1;
          end else begin
            phase_d = PH_WDROP;
          end
        end
        EV_RD_NEXT: if (phase_q == PH_RD) begin
          ack = 1'b1; step_full = 1'b1;
        end
        EV_RESTART: begin
          ack = 1'b1; buf_clr = 1'b1; phase_d = PH_IDLE;
        end
        EV_STOP: begin
          ack = 1'b1;
          if (phase_q == PH_WDAT && buf_any) begin
            phase_d = PH_COMMIT; tmr_start = 1'b1;
          end else begin
            buf_clr = 1'b1; phase_d = PH_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q      <= PH_INIT;
      resp_valid_q <= 1'b0;
      resp_ack_q   <= 1'b0;
      busy_q       <= 1'b1;
      hi_q         <= '0;
    end else begin
      phase_q      <= phase_d;
      resp_valid_q <= ev_valid;
      resp_ack_q   <= ack;
      busy_q       <= (phase_d == PH_INIT) || (phase_d == PH_COMMIT);
      if (hi_ld) hi_q <= ev_byte[HI_W-1:0];
    end
  end

  eepg_addr_ctr #(.AW(AW), .OW(OFS_BITS)) addr_i (
    .clk       (clk),
    .rst       (rst),
    .load      (ld),
    .load_val  ({hi_q, ev_byte}),
    .step_page (step_page),
    .step_full (step_full),
    .addr      (addr_q)
  );

  eepg_page_buf #(.OW(OFS_BITS), .DW(8)) buf_i (
    .clk      (clk),
    .rst      (rst),
    .clr      (buf_clr),
    .wr_en    (buf_wr),
    .wr_idx   (addr_q[OFS_BITS-1:0]),
    .wr_data  (ev_byte),
    .rd_idx   (cnt_q[OFS_BITS-1:0]),
    .rd_data  (buf_data),
    .rd_mark  (buf_mark),
    .any_mark (buf_any)
  );

  eepg_hold_timer #(.CW(CW)) tmr_i (
    .clk   (clk),
    .rst   (rst),
    .start (tmr_start),
    .run   (tmr_run),
    .cnt   (cnt_q)
  );

  // init sweep and commit walk share the array write port
  always_comb begin
    if (phase_q == PH_INIT) begin
      arr_we    = 1'b1;
      arr_waddr = cnt_q[AW-1:0];
      arr_wdata = 8'hFF;
    end else begin
      arr_we    = (phase_q == PH_COMMIT) && (cnt_q < CW'(SLOTS)) && buf_mark;
      arr_waddr = {addr_q[AW-1:OFS_BITS], cnt_q[OFS_BITS-1:0]};
      arr_wdata = buf_data;
    end
  end

  eepg_array #(.AW(AW), .DW(8)) arr_i (
    .clk   (clk),
    .we    (arr_we),
    .waddr (arr_waddr),
    .wdata (arr_wdata),
    .raddr (addr_q),
    .rdata (arr_rdata)
  );

  assign resp_valid = resp_valid_q;
  assign resp_ack   = resp_ack_q;
  assign resp_data  = arr_rdata;
  assign busy       = busy_q;
endmodule

// File: rtl/eepg_pager_chk.sv
module eepg_pager_chk
  import eepg_pkg::*;
#(
  parameter int OFS_BITS = 6,
  parameter int HOLD_CYC = 80
) (
  input logic       clk,
  input logic       rst,
  input logic       ev_valid,
  input logic [2:0] ev_kind,
  input logic       resp_valid,
  input logic       resp_ack,
  input logic       busy,
  input logic       arr_we,
  input logic [2:0] phase_q
);
  localparam int SLOTS = 1 << OFS_BITS;
  localparam int HOLD  = (HOLD_CYC < SLOTS) ? SLOTS : HOLD_CYC;

  logic busy_prev, in_commit;
  int   run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_prev <= 1'b1;
      in_commit <= 1'b0;
      run_cnt   <= 0;
    end else begin
      busy_prev <= busy;
      if (busy && !busy_prev) begin
        run_cnt   <= 1;
        in_commit <= 1'b1;
      end else if (busy) begin
        run_cnt <= run_cnt + 1;
      end else begin
        in_commit <= 1'b0;
      end
    end
  end

  p_resp_follows_ev_r2: assert property (@(posedge clk) disable iff (rst)
    ev_valid |=> resp_valid);

  p_no_stray_resp_r2: assert property (@(posedge clk) disable iff (rst)
    !ev_valid |=> !resp_valid);

  p_busy_refuses_r3: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && busy) |=> !resp_ack);

  p_addr_order_r4: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_kind == 3'd3 && phase_q != PH_WLO) |=> !resp_ack);

  p_commit_from_stop_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(ev_valid && ev_kind == 3'd7));

  p_commit_len_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && busy_prev && in_commit) |-> run_cnt == HOLD);

  p_write_only_busy_r6: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);

  p_protect_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_kind == 3'd4 && phase_q == PH_WDROP) |=> !resp_ack);
endmodule

bind eepg_pager eepg_pager_chk #(.OFS_BITS(OFS_BITS), .HOLD_CYC(HOLD_CYC)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .ev_valid   (ev_valid),
  .ev_kind    (ev_kind),
  .resp_valid (resp_valid),
  .resp_ack   (resp_ack),
  .busy       (busy),
  .arr_we     (arr_we),
  .phase_q    (phase_q)
);

// File: tb/eepg_pager_tb_top.sv
`timescale 1ns/1ps
module eepg_pager_tb_top;
  localparam int PAGE_BITS = 5;
  localparam int OFS_BITS  = 6;
  localparam int HOLD_CYC  = 80;
  localparam int DEPTH     = 1 << (PAGE_BITS + OFS_BITS);
  localparam int SLOTS     = 1 << OFS_BITS;
  localparam int HOLD      = HOLD_CYC;

  localparam int K_SWR = 0, K_SRD = 1, K_AHI = 2, K_ALO = 3;
  localparam int K_WD  = 4, K_RN  = 5, K_RS  = 6, K_SP  = 7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ev_valid = 1'b0;
  logic [2:0] ev_kind = 3'd0;
  logic [7:0] ev_byte = 8'd0;
  logic       wp = 1'b0;
  logic       resp_valid, resp_ack, busy;
  logic [7:0] resp_data;

  always #4 clk = ~clk;

  eepg_pager #(.PAGE_BITS(PAGE_BITS), .OFS_BITS(OFS_BITS), .HOLD_CYC(HOLD_CYC)) dut_i (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_byte(ev_byte),
    .wp(wp), .resp_valid(resp_valid), .resp_ack(resp_ack), .resp_data(resp_data), .busy(busy)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  logic [7:0] mdl_mem [DEPTH];
  logic [7:0] mdl_buf [SLOTS];
  bit         mdl_mark [SLOTS];
  bit         mdl_any;
  bit         mdl_busy;
  int         mdl_addr;
  int         mdl_ph;   // 0 idle, 1 hi, 2 lo, 3 data, 4 dropped, 5 read
  int         mdl_hi;

  function automatic int next_in_page(input int a);
    return (a / SLOTS) * SLOTS + ((a + 1) % SLOTS);
  endfunction

  function automatic int next_in_array(input int a);
    return (a + 1) % DEPTH;
  endfunction

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic chk_eq(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic clr_buf();
    for (int i = 0; i < SLOTS; i++) mdl_mark[i] = 1'b0;
    mdl_any = 1'b0;
  endtask

  task automatic ev(input int k, input logic [7:0] b, input string rq);
    bit e_ack, e_rd, e_commit;
    logic [7:0] e_dat;
    e_ack = 0; e_rd = 0; e_commit = 0; e_dat = 8'h00;
    if (!mdl_busy) begin
      case (k)
        K_SWR: begin e_ack = 1; clr_buf(); mdl_ph = 1; end
        K_SRD: begin
          e_ack = 1; clr_buf(); e_rd = 1; e_dat = mdl_mem[mdl_addr];
          mdl_addr = next_in_array(mdl_addr); mdl_ph = 5;
        end
        K_AHI: if (mdl_ph == 1) begin e_ack = 1; mdl_hi = int'(b); mdl_ph = 2; end
        K_ALO: if (mdl_ph == 2) begin
          e_ack = 1; mdl_addr = (mdl_hi * 256 + int'(b)) % DEPTH; mdl_ph = 3;
        end
        K_WD: if (mdl_ph == 3) begin
          if (mdl_any || !wp) begin
            e_ack = 1; mdl_buf[mdl_addr % SLOTS] = b; mdl_mark[mdl_addr % SLOTS] = 1'b1;
            mdl_any = 1'b1; mdl_addr = next_in_page(mdl_addr);
          end else begin
            mdl_ph = 4;
          end
        end
        K_RN: if (mdl_ph == 5) begin
          e_ack = 1; e_rd = 1; e_dat = mdl_mem[mdl_addr]; mdl_addr = next_in_array(mdl_addr);
        end
        K_RS: begin e_ack = 1; clr_buf(); mdl_ph = 0; end
        default: begin
          e_ack = 1;
          if (mdl_ph == 3 && mdl_any) begin
            for (int i = 0; i < SLOTS; i++)
              if (mdl_mark[i]) mdl_mem[(mdl_addr / SLOTS) * SLOTS + i] = mdl_buf[i];
            e_commit = 1; mdl_busy = 1;
          end
          clr_buf(); mdl_ph = 0;
        end
      endcase
    end
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = 3'(k); ev_byte = b;
    @(negedge clk);
    ev_valid = 1'b0;
    chk_eq({rq, " R2 resp_valid"}, int'(resp_valid), 1);
    chk_eq({rq, " ack"}, int'(resp_ack), int'(e_ack));
    if (e_ack && e_rd) chk_eq({rq, " read data"}, int'(resp_data), int'(e_dat));
    if (e_commit) chk_eq("R6 busy after stop", int'(busy), 1);
  endtask

  task automatic wait_ready(input int exp, input string rq);
    int n = 0;
    while (busy === 1'b1 && n < DEPTH + HOLD + 16) begin
      n++;
      @(negedge clk);
    end
    chk_eq({rq, " busy cycles"}, n, exp);
    mdl_busy = 0;
  endtask

  task automatic stop_and_settle(input string rq);
    ev(K_SP, 8'h00, rq);
    if (mdl_busy) wait_ready(HOLD, "R6");
    else chk_eq("R7 no busy", int'(busy), 0);
  endtask

  task automatic set_addr(input int a, input string rq);
    ev(K_SWR, 8'h00, rq);
    ev(K_AHI, 8'((a >> 8) & 8'hFF), rq);
    ev(K_ALO, 8'(a & 8'hFF), rq);
  endtask

  task automatic rd_seq(input int a, input int n, input string rq);
    set_addr(a, rq);
    ev(K_RS, 8'h00, "R7");
    ev(K_SRD, 8'h00, rq);
    for (int i = 1; i < n; i++) ev(K_RN, 8'h00, rq);
    stop_and_settle("R7");
  endtask

  task automatic wr_seq(input int a, input int n, input string rq);
    set_addr(a, rq);
    for (int i = 0; i < n; i++) ev(K_WD, 8'($urandom), rq);
    stop_and_settle(rq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e_ed07));
    for (int i = 0; i < DEPTH; i++) mdl_mem[i] = 8'hFF;
    clr_buf();
    mdl_addr = 0; mdl_ph = 0; mdl_hi = 0; mdl_busy = 1;

    // R1: reset state
    repeat (4) @(negedge clk);
    chk_eq("R1 resp_valid in reset", int'(resp_valid), 0);
    chk_eq("R1 busy in reset", int'(busy), 1);
    rst = 1'b0;
    ev(K_SRD, 8'h00, "R3 select during init");
    wait_ready(DEPTH - 2, "R1");

    // R2: no response without an event
    @(negedge clk);
    chk_eq("R2 idle resp_valid", int'(resp_valid), 0);

    // R9/R1: immediate read of erased array
    ev(K_SRD, 8'h00, "R1 erased read");
    ev(K_RN, 8'h00, "R9");
    stop_and_settle("R9");

    // R4: single-byte write with bit 15 and out-of-range bits set
    set_addr(16'hF923, "R4");
    ev(K_WD, 8'hA5, "R6");
    stop_and_settle("R6");
    rd_seq(16'h0122, 3, "R6 neighbours untouched");

    // R5: page wrap with 70 bytes from offset 60 of page 5
    wr_seq(5 * SLOTS + 60, 70, "R5");
    rd_seq(5 * SLOTS, SLOTS + 2, "R5 readback");

    // R10: counter after a write, then immediate read
    wr_seq(9 * SLOTS + 62, 3, "R10");
    ev(K_SRD, 8'h00, "R10 immediate read");
    stop_and_settle("R10");

    // R9: read wraps over the array top
    rd_seq(DEPTH - 2, 4, "R9 wrap");

    // R8: protected write refused
    wp = 1'b1;
    set_addr(3 * SLOTS, "R8");
    ev(K_WD, 8'h11, "R8 first byte");
    ev(K_WD, 8'h22, "R8 later byte");
    stop_and_settle("R8");
    wp = 1'b0;
    rd_seq(3 * SLOTS, 2, "R8 unchanged");
    // R8: protect raised after first byte has no effect
    set_addr(4 * SLOTS + 10, "R8");
    ev(K_WD, 8'h33, "R8");
    wp = 1'b1;
    ev(K_WD, 8'h44, "R8 late protect");
    stop_and_settle("R8");
    wp = 1'b0;
    rd_seq(4 * SLOTS + 10, 2, "R8 late readback");

    // R3: polling during commit
    set_addr(7 * SLOTS + 1, "R3");
    ev(K_WD, 8'h5A, "R3");
    ev(K_SP, 8'h00, "R3");
    ev(K_SWR, 8'h00, "R3 poll write");
    ev(K_SRD, 8'h00, "R3 poll read");
    wait_ready(HOLD - 4, "R3");
    rd_seq(7 * SLOTS, 3, "R3 readback");

    // R11: out-of-phase events
    ev(K_RN, 8'h00, "R11 next outside read");
    ev(K_SWR, 8'h00, "R11");
    ev(K_WD, 8'h77, "R11 data before address");
    ev(K_ALO, 8'h10, "R11 low before high");
    ev(K_AHI, 8'h00, "R11");
    ev(K_AHI, 8'h00, "R11 second high");
    stop_and_settle("R7");
    // R7: restart after data discards it
    set_addr(2 * SLOTS + 5, "R7");
    ev(K_WD, 8'h99, "R7");
    ev(K_RS, 8'h00, "R7 restart drops");
    chk_eq("R7 no busy on restart", int'(busy), 0);
    rd_seq(2 * SLOTS + 5, 1, "R7 unchanged");

    // random mix
    for (int t = 0; t < 150; t++) begin
      int sel = int'($urandom_range(0, 9));
      int a   = int'($urandom_range(0, 65535));
      if (sel < 4) begin
        wp = ($urandom_range(0, 5) == 0);
        wr_seq(a, int'($urandom_range(1, 70)), "R5 random write");
        wp = 1'b0;
      end else if (sel < 7) begin
        rd_seq(a, int'($urandom_range(1, 8)), "R9 random read");
      end else if (sel < 9) begin
        ev(K_SRD, 8'h00, "R10 random immediate");
        ev(K_RN, 8'h00, "R9");
        stop_and_settle("R9");
      end else begin
        ev(int'($urandom_range(0, 6)), 8'($urandom), "R11 random event");
        stop_and_settle("R11");
      end
    end
    for (int p = 0; p < 4; p++) rd_seq(p * SLOTS, SLOTS, "R6 page sweep");

    report();
    $finish;
  end
endmodule